// File: doc/BRIEF.md
# Channel Fault Flag Latch and Diagnosis Encoder

This block gathers load and protection fault indications for a group of switched channels (eight by default). It condenses them into one diagnosis word with two bits per channel, ready to be loaded into a serial shift register. Three kinds of fault are captured. Overload and overtemperature flags come from the channel controllers. Open-load and short-to-ground comparator results count only while the channel is switched off. Each captured fault stays latched until the serial interface sends a clear pulse after a valid transfer.

The comparator inputs pass through a per-channel glitch filter before they are latched. Its length is programmable at run time. Alongside the diagnosis word, the block produces a status byte. This byte is a registered copy of each channel's drain-voltage comparator.

Top module: `diag_flag_encoder`

## Requirements
- R1: Channel n occupies bits 2n+1:2n of `diag_word`. The code values are 2'b11 for healthy, 2'b01 for open load, 2'b00 for short to ground and 2'b10 for overload or overtemperature.
- R2: When `ovl_in[n]` or `ovt_in[n]` is high at a clock edge with `clr` low, channel n reports 2'b10 from that edge on. The code holds after the inputs fall, until a clear.
- R3: `open_cmp[n]` has no effect while `ch_on[n]` is 1. While the channel is off, it latches an open-load flag.
- R4: `gnd_cmp[n]` has no effect while `ch_on[n]` is 1. While the channel is off, it latches a short-to-ground flag. This flag is independent of the open-load flag, so a channel that already shows open load moves to 2'b00.
- R5: When more than one flag is set on a channel, the reported code follows this priority: protection (10) first, then short to ground (00), then open load (01).
- R6: A clock edge with `clr` high clears every flag, so the whole word reads all ones after that edge.
- R7: A fault condition still present at a clearing edge is latched again at the next edge.
- R8: A comparator condition (comparator high and channel off) latches only at the edge where it has been seen on `filt_len`+1 consecutive edges. A shorter run is ignored.
- R9: `status[n]` equals `vds_low[n]` sampled at the previous clock edge. It reads 8'h00 in reset.
- R10: An active-low `rst_n` asynchronously clears all flags, so every channel reports 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| filt_len | input | FILT_W | Extra edges a comparator condition must hold |
| ch_on | input | NCH | Channel commanded on |
| open_cmp | input | NCH | Open-load comparator result |
| gnd_cmp | input | NCH | Short-to-ground comparator result |
| ovl_in | input | NCH | Overload flag from channel controller |
| ovt_in | input | NCH | Overtemperature flag from channel controller |
| vds_low | input | NCH | Drain voltage below open-load threshold |
| clr | input | 1 | Clear pulse after a valid serial transfer |
| diag_word | output | 2*NCH | Two-bit diagnosis code per channel |
| status | output | NCH | Registered drain-voltage status |

## Verification
Protection faults, cleared flags and status changes all become visible at the first clock edge after the stimulus. A comparator fault becomes visible at edge `filt_len`+1 of an unbroken run. The bench drives inputs on falling edges and reads outputs at the next falling edge. It therefore samples each single-edge result exactly one edge later. For the filter, it checks the word after `filt_len` edges, where the fault must still be absent, and again after `filt_len`+1 edges, where it must be present. A re-latch after a clear is checked at the edge right after the clearing one.

// File: rtl/diag_flag_encoder.sv
module diag_flag_encoder #(
  parameter int NCH    = 8,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILT_W-1:0] filt_len,
  input  logic [NCH-1:0]    ch_on,
  input  logic [NCH-1:0]    open_cmp,
  input  logic [NCH-1:0]    gnd_cmp,
  input  logic [NCH-1:0]    ovl_in,
  input  logic [NCH-1:0]    ovt_in,
  input  logic [NCH-1:0]    vds_low,
  input  logic              clr,
  output logic [2*NCH-1:0]  diag_word,
  output logic [NCH-1:0]    status
);

  localparam logic [1:0] C_SHORT = 2'b00;
  localparam logic [1:0] C_OPEN  = 2'b01;
  localparam logic [1:0] C_PROT  = 2'b10;
  localparam logic [1:0] C_OK    = 2'b11;

  logic [NCH-1:0] ol_q, sg_q, pr_q;
  logic [NCH-1:0] ol_hit, sg_hit;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [FILT_W-1:0] ol_cnt, sg_cnt;
    logic ol_cond, sg_cond;

    assign ol_cond = open_cmp[i] & ~ch_on[i];
    assign sg_cond = gnd_cmp[i]  & ~ch_on[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ol_cnt <= '0;
        sg_cnt <= '0;
      end else begin
        if (!ol_cond)                ol_cnt <= '0;
        else if (ol_cnt < filt_len)  ol_cnt <= ol_cnt + 1'b1;
        if (!sg_cond)                sg_cnt <= '0;
        else if (sg_cnt < filt_len)  sg_cnt <= sg_cnt + 1'b1;
      end
    end

    assign ol_hit[i] = ol_cond && (ol_cnt >= filt_len);
    assign sg_hit[i] = sg_cond && (sg_cnt >= filt_len);

    assign diag_word[2*i+1 -: 2] = pr_q[i] ? C_PROT  :
                                   sg_q[i] ? C_SHORT :
                                   ol_q[i] ? C_OPEN  : C_OK;

    p_prot_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((ovl_in[i] | ovt_in[i]) && !clr) |=> diag_word[2*i+1 -: 2] == C_PROT);

    p_open_on_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_on[i] && !ol_q[i]) |=> !ol_q[i]);

    p_short_on_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_on[i] && !sg_q[i]) |=> !sg_q[i]);

    p_status_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> status[i] == $past(vds_low[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ol_q   <= '0;
      sg_q   <= '0;
      pr_q   <= '0;
      status <= '0;
    end else begin
      ol_q   <= clr ? '0 : (ol_q | ol_hit);
      sg_q   <= clr ? '0 : (sg_q | sg_hit);
      pr_q   <= clr ? '0 : (pr_q | ovl_in | ovt_in);
      status <= vds_low;
    end
  end

  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> diag_word == '1);

endmodule

// File: tb/tb_diag_flag_encoder.sv
module tb_diag_flag_encoder;
  localparam int NCH = 8;
  localparam int FW  = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [FW-1:0]   filt_len;
  logic [NCH-1:0]  ch_on, open_cmp, gnd_cmp, ovl_in, ovt_in, vds_low;
  logic            clr;
  logic [2*NCH-1:0] diag_word;
  logic [NCH-1:0]  status;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  diag_flag_encoder #(.NCH(NCH), .FILT_W(FW)) dut (
    .clk(clk), .rst_n(rst_n), .filt_len(filt_len), .ch_on(ch_on),
    .open_cmp(open_cmp), .gnd_cmp(gnd_cmp), .ovl_in(ovl_in), .ovt_in(ovt_in),
    .vds_low(vds_low), .clr(clr), .diag_word(diag_word), .status(status));

  // fields: on[48:41] ol[40:33] sg[32:25] prot[24:17] clr[16] expected[15:0]
  localparam logic [48:0] VEC [12] = '{
    {8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 16'hFFFD},  // ch0 open load
    {8'h00, 8'h00, 8'h02, 8'h00, 1'b0, 16'hFFF1},  // ch1 short
    {8'h00, 8'h00, 8'h00, 8'h04, 1'b0, 16'hFFE1},  // ch2 overload
    {8'h08, 8'h08, 8'h08, 8'h00, 1'b0, 16'hFFE1},  // ch3 on: ignored
    {8'h00, 8'h00, 8'h01, 8'h00, 1'b0, 16'hFFE0},  // ch0 short beats open
    {8'h00, 8'h00, 8'h00, 8'h01, 1'b0, 16'hFFE2},  // ch0 protection wins
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'hFFFF},  // clear
    {8'h00, 8'h10, 8'h00, 8'h00, 1'b1, 16'hFFFF},  // clear with fault present
    {8'h00, 8'h10, 8'h00, 8'h00, 1'b0, 16'hFDFF},  // re-latched
    {8'h00, 8'h80, 8'h00, 8'h80, 1'b0, 16'hBDFF},  // ch7 overtemp over open
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'hBDFF},  // hold
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'hFFFF}   // clear
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; filt_len = '0; clr = 1'b0;
    ch_on = '0; open_cmp = '0; gnd_cmp = '0; ovl_in = '0; ovt_in = '0; vds_low = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset word", diag_word, 16'hFFFF);
    chk("R9 reset status", {8'h00, status}, 16'h0000);

    for (int i = 0; i < 12; i++) begin
      ch_on    = VEC[i][48:41];
      open_cmp = VEC[i][40:33];
      gnd_cmp  = VEC[i][32:25];
      ovl_in   = VEC[i][24:17] & 8'h0F;
      ovt_in   = VEC[i][24:17] & 8'hF0;
      clr      = VEC[i][16];
      @(negedge clk);
      chk($sformatf("R1 R2 R3 R4 R5 R6 R7 vector %0d", i), diag_word, VEC[i][15:0]);
    end
    ch_on = '0; open_cmp = '0; gnd_cmp = '0; ovl_in = '0; ovt_in = '0; clr = 1'b0;

    filt_len = 4'd3;
    open_cmp = 8'h20;
    repeat (3) @(negedge clk);
    chk("R8 short run ignored", diag_word, 16'hFFFF);
    open_cmp = 8'h00;
    @(negedge clk);
    open_cmp = 8'h20;
    repeat (3) @(negedge clk);
    chk("R8 one edge before latch", diag_word, 16'hFFFF);
    @(negedge clk);
    chk("R8 latched at filt_len+1", diag_word, 16'hF7FF);
    open_cmp = 8'h00;

    gnd_cmp = 8'h40; ch_on = 8'h40;
    repeat (5) @(negedge clk);
    chk("R4 short ignored while on", diag_word, 16'hF7FF);
    gnd_cmp = 8'h00; ch_on = 8'h00;

    vds_low = 8'hA5;
    chk("R9 status before edge", {8'h00, status}, 16'h0000);
    @(negedge clk);
    chk("R9 status after edge", {8'h00, status}, 16'h00A5);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset mid run word", diag_word, 16'hFFFF);
    chk("R10 reset mid run status", {8'h00, status}, 16'h0000);
    rst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule